// File: doc/BRIEF.md
# Address Region Memory Firewall

This block sits in front of a memory target port and decides, per transaction, whether the access may reach the memory. Every request carries an address, a direction, a 3-bit compartment identifier (CID), a secure attribute and a privilege attribute. The block looks the address up against a bank of programmable base regions. Each base region has an inclusive start page and end page on a 4 KB granule, plus an access rule. It then applies the rule of the winning region, and forwards allowed traffic to the memory one clock later.

A refused write never reaches the memory. A refused read returns zero. Either kind of refusal raises a one-cycle illegal-access pulse. Two extra edge regions carry only bounds. They open the address ranges on either side of the guarded memory to any master. One debug CID always bypasses the rules. A single-cycle configuration port writes one whole region at a time.

Top module: `memfw_region_guard`

## Requirements
- R1: There are 11 base regions, indices 0 to 10, and 2 edge regions, indices 11 and 12. A configuration write with `cfg_we` high stores enable, start page, end page and rule into region `cfg_idx` at the clock edge. Page number = address bits [ADDR_W-1:12], and both bounds are inclusive. After reset every region is disabled.
- R2: A request sampled at a clock edge produces its outcome right after that edge. Either `mem_valid` is high, or `illegal_evt` is high; never both. `resp_valid` is high in both cases, and all three outputs are low when no request was sampled.
- R3: When several enabled base regions contain the page, the lowest-numbered one decides the access. Edge regions are consulted only when no enabled base region matches.
- R4: When the winning region has its secure bit set, a non-secure request is refused.
- R5: When the winning region has CID filtering off, and its privilege bit is set, an unprivileged request is refused.
- R6: When the winning region has CID filtering on, a read needs `rd_map[cid]` = 1 and a write needs `wr_map[cid]` = 1.
- R7: When the winning region has CID filtering on and `pv_map[cid]` = 1, an unprivileged request is refused.
- R8: A page that matches an enabled edge region, and no enabled base region, is allowed for every CID and attribute combination.
- R9: A page that matches no enabled region is allowed only for CID 1 with the secure and privileged attributes both set.
- R10: A request with CID 7 is always allowed.
- R11: On an allowed access, `mem_addr`, `mem_write` and `mem_wdata` carry the request, and a read returns `mem_rdata` on `resp_rdata`. On a refused access, `mem_valid` stays low and `resp_rdata` is zero.
- R12: After reset and before any request, `mem_valid`, `resp_valid` and `illegal_evt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one region this cycle |
| cfg_idx | input | IDX_W | Region index (base 0..10, edge 11..12) |
| cfg_en | input | 1 | Region enable |
| cfg_start_pg | input | PG_W | First page of the region |
| cfg_end_pg | input | PG_W | Last page of the region |
| cfg_sec | input | 1 | Region requires secure access |
| cfg_priv | input | 1 | Privilege required when CID filtering is off |
| cfg_cid_filt | input | 1 | CID filtering on |
| cfg_rd_map | input | 8 | Per-CID read enable |
| cfg_wr_map | input | 8 | Per-CID write enable |
| cfg_pv_map | input | 8 | Per-CID privilege requirement |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | DATA_W | Write data |
| req_cid | input | 3 | Compartment identifier of the master |
| req_secure | input | 1 | Secure attribute |
| req_priv | input | 1 | Privileged attribute |
| mem_valid | output | 1 | Forwarded access to the memory |
| mem_write | output | 1 | Forwarded direction |
| mem_addr | output | ADDR_W | Forwarded address |
| mem_wdata | output | DATA_W | Forwarded write data |
| mem_rdata | input | DATA_W | Read data from the memory for the forwarded address |
| resp_valid | output | 1 | Outcome of the previous request is present |
| resp_rdata | output | DATA_W | Read data, zero when refused |
| illegal_evt | output | 1 | Illegal-access pulse |

## Verification
The hardest situation to reach is a page claimed by two overlapping enabled base regions whose rules disagree, while an edge region also covers a page that a base region owns. Only a deliberate layout of bounds shows whether priority is applied in the right order. The bench programs such a layout: base regions 0 and 1 share page 4, and edge region 12 overlaps base region 3 on page 15. It then sweeps every page, every CID, both attribute bits and both directions. A second layout disables region 0 so that its pages fall through to other regions, and a reset layout exercises the default rule on its own.

// File: rtl/memfw_pkg.sv
package memfw_pkg;
    localparam int CID_W = 3;
    localparam int NCID  = 1 << CID_W;

    typedef struct packed {
        logic            sec;
        logic            priv;
        logic            cid_filt;
        logic [NCID-1:0] rd_map;
        logic [NCID-1:0] wr_map;
        logic [NCID-1:0] pv_map;
    } rule_t;
endpackage

// File: rtl/memfw_region_bank.sv
module memfw_region_bank
    import memfw_pkg::*;
#(
    parameter int PG_W     = 20,
    parameter int NUM_BASE = 11,
    parameter int NUM_EDGE = 2,
    localparam int NTOT    = NUM_BASE + NUM_EDGE,
    localparam int IDX_W   = $clog2(NTOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             cfg_en,
    input  logic [PG_W-1:0]  cfg_start_pg,
    input  logic [PG_W-1:0]  cfg_end_pg,
    input  rule_t            cfg_rule,
    input  logic [PG_W-1:0]  look_pg,
    output logic [NUM_BASE-1:0] base_hit,
    output logic             edge_hit,
    output rule_t            rules [NUM_BASE]
);
    logic            en_d    [NTOT];
    logic            en_q    [NTOT];
    logic [PG_W-1:0] start_d [NTOT];
    logic [PG_W-1:0] start_q [NTOT];
    logic [PG_W-1:0] end_d   [NTOT];
    logic [PG_W-1:0] end_q   [NTOT];
    rule_t           rule_d  [NUM_BASE];
    rule_t           rule_q  [NUM_BASE];
    logic [NUM_EDGE-1:0] edge_vec;

    always_comb begin
        for (int i = 0; i < NTOT; i++) begin
            en_d[i]    = en_q[i];
            start_d[i] = start_q[i];
            end_d[i]   = end_q[i];
            if (cfg_we && (int'(cfg_idx) == i)) begin
                en_d[i]    = cfg_en;
                start_d[i] = cfg_start_pg;
                end_d[i]   = cfg_end_pg;
            end
        end
        for (int i = 0; i < NUM_BASE; i++) begin
            rule_d[i] = rule_q[i];
            if (cfg_we && (int'(cfg_idx) == i)) rule_d[i] = cfg_rule;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NTOT; i++) begin
                en_q[i]    <= 1'b0;
                start_q[i] <= '0;
                end_q[i]   <= '0;
            end
            for (int i = 0; i < NUM_BASE; i++) rule_q[i] <= '0;
        end else begin
            for (int i = 0; i < NTOT; i++) begin
                en_q[i]    <= en_d[i];
                start_q[i] <= start_d[i];
                end_q[i]   <= end_d[i];
            end
            for (int i = 0; i < NUM_BASE; i++) rule_q[i] <= rule_d[i];
        end
    end

    for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
        assign base_hit[g] = en_q[g] && (look_pg >= start_q[g]) && (look_pg <= end_q[g]);
        assign rules[g]    = rule_q[g];
    end
    for (genvar g = 0; g < NUM_EDGE; g++) begin : g_edge
        assign edge_vec[g] = en_q[NUM_BASE+g] && (look_pg >= start_q[NUM_BASE+g])
                             && (look_pg <= end_q[NUM_BASE+g]);
    end
    assign edge_hit = |edge_vec;

    AST_CFG_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> (int'(cfg_idx) < NTOT)); // R1
endmodule

// File: rtl/memfw_rule_eval.sv
module memfw_rule_eval
    import memfw_pkg::*;
#(
    parameter int NUM_BASE    = 11,
    parameter int DEBUG_CID   = 7,
    parameter int DEFAULT_CID = 1
) (
    input  logic [NUM_BASE-1:0] base_hit,
    input  logic                edge_hit,
    input  rule_t               rules [NUM_BASE],
    input  logic [CID_W-1:0]    cid,
    input  logic                secure,
    input  logic                priv,
    input  logic                write,
    output logic                allow
);
    rule_t sel;
    logic  found;
    logic  sec_ok, acc_ok, pv_ok;

    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_BASE; i++) begin
            if (!found && base_hit[i]) begin
                found = 1'b1;
                sel   = rules[i];
            end
        end
        sec_ok = !sel.sec || secure;
        if (sel.cid_filt) begin
            acc_ok = write ? sel.wr_map[cid] : sel.rd_map[cid];
            pv_ok  = !sel.pv_map[cid] || priv;
        end else begin
            acc_ok = 1'b1;
            pv_ok  = !sel.priv || priv;
        end
        if (int'(cid) == DEBUG_CID)  allow = 1'b1;
        else if (found)              allow = sec_ok && acc_ok && pv_ok;
        else if (edge_hit)           allow = 1'b1;
        else                         allow = (int'(cid) == DEFAULT_CID) && secure && priv;
    end
endmodule

// File: rtl/memfw_region_guard.sv
module memfw_region_guard
    import memfw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int GRAN_LG    = 12,
    parameter int NUM_BASE   = 11,
    parameter int NUM_EDGE   = 2,
    parameter int DEBUG_CID  = 7,
    localparam int PG_W      = ADDR_W - GRAN_LG,
    localparam int IDX_W     = $clog2(NUM_BASE + NUM_EDGE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_en,
    input  logic [PG_W-1:0]   cfg_start_pg,
    input  logic [PG_W-1:0]   cfg_end_pg,
    input  logic              cfg_sec,
    input  logic              cfg_priv,
    input  logic              cfg_cid_filt,
    input  logic [NCID-1:0]   cfg_rd_map,
    input  logic [NCID-1:0]   cfg_wr_map,
    input  logic [NCID-1:0]   cfg_pv_map,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CID_W-1:0]  req_cid,
    input  logic              req_secure,
    input  logic              req_priv,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              illegal_evt
);
    typedef struct packed {
        logic              fwd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              resp;
        logic              rd_ok;
        logic              bad;
    } pipe_t;

    rule_t               cfg_rule;
    logic [NUM_BASE-1:0] base_hit;
    logic                edge_hit;
    rule_t               rules [NUM_BASE];
    logic                allow;
    pipe_t               st_d, st_q;

    assign cfg_rule = '{sec: cfg_sec, priv: cfg_priv, cid_filt: cfg_cid_filt,
                        rd_map: cfg_rd_map, wr_map: cfg_wr_map, pv_map: cfg_pv_map};

    memfw_region_bank #(
        .PG_W(PG_W), .NUM_BASE(NUM_BASE), .NUM_EDGE(NUM_EDGE)
    ) bank_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_en(cfg_en), .cfg_start_pg(cfg_start_pg), .cfg_end_pg(cfg_end_pg),
        .cfg_rule(cfg_rule), .look_pg(req_addr[ADDR_W-1:GRAN_LG]),
        .base_hit(base_hit), .edge_hit(edge_hit), .rules(rules)
    );

    memfw_rule_eval #(
        .NUM_BASE(NUM_BASE), .DEBUG_CID(DEBUG_CID), .DEFAULT_CID(1)
    ) eval_i (
        .base_hit(base_hit), .edge_hit(edge_hit), .rules(rules),
        .cid(req_cid), .secure(req_secure), .priv(req_priv),
        .write(req_write), .allow(allow)
    );

    always_comb begin
        st_d       = '0;
        st_d.resp  = req_valid;
        st_d.fwd   = req_valid && allow;
        st_d.bad   = req_valid && !allow;
        st_d.rd_ok = req_valid && allow && !req_write;
        if (req_valid && allow) begin
            st_d.wr    = req_write;
            st_d.addr  = req_addr;
            st_d.wdata = req_write ? req_wdata : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_valid   = st_q.fwd;
    assign mem_write   = st_q.wr;
    assign mem_addr    = st_q.addr;
    assign mem_wdata   = st_q.wdata;
    assign resp_valid  = st_q.resp;
    assign illegal_evt = st_q.bad;
    assign resp_rdata  = st_q.rd_ok ? mem_rdata : '0;

    AST_DENY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_evt |-> !mem_valid); // R11
    AST_DENY_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !mem_valid) |-> (resp_rdata == '0)); // R11
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (mem_valid != illegal_evt)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && !mem_valid && !illegal_evt)); // R2
    AST_DEBUG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && int'(req_cid) == DEBUG_CID) |=> (mem_valid && !illegal_evt)); // R10
    AST_EDGE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && base_hit == '0 && edge_hit) |=> mem_valid); // R8
    AST_NOMATCH_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && base_hit == '0 && !edge_hit && int'(req_cid) != DEBUG_CID
         && !(req_cid == 3'd1 && req_secure && req_priv)) |=> illegal_evt); // R9
endmodule

// File: tb/memfw_region_guard_tb.sv
module memfw_region_guard_tb_top;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int PG_W   = 4;
    localparam int NB     = 11;
    localparam int NT     = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic            cfg_we = 0;
    logic [3:0]      cfg_idx = 0;
    logic            cfg_en = 0;
    logic [PG_W-1:0] cfg_start_pg = 0, cfg_end_pg = 0;
    logic            cfg_sec = 0, cfg_priv = 0, cfg_cid_filt = 0;
    logic [7:0]      cfg_rd_map = 0, cfg_wr_map = 0, cfg_pv_map = 0;
    logic            req_valid = 0, req_write = 0;
    logic [ADDR_W-1:0] req_addr = 0;
    logic [DATA_W-1:0] req_wdata = 0;
    logic [2:0]      req_cid = 0;
    logic            req_secure = 0, req_priv = 0;
    logic            mem_valid, mem_write, resp_valid, illegal_evt;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata, resp_rdata;

    assign mem_rdata = {16'hC0DE, mem_addr};

    memfw_region_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
        .cfg_start_pg(cfg_start_pg), .cfg_end_pg(cfg_end_pg), .cfg_sec(cfg_sec),
        .cfg_priv(cfg_priv), .cfg_cid_filt(cfg_cid_filt), .cfg_rd_map(cfg_rd_map),
        .cfg_wr_map(cfg_wr_map), .cfg_pv_map(cfg_pv_map), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_cid(req_cid), .req_secure(req_secure), .req_priv(req_priv),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .resp_valid(resp_valid),
        .resp_rdata(resp_rdata), .illegal_evt(illegal_evt)
    );

    int checks = 0;
    int fails  = 0;

    // bench copy of the programmed layout (R1)
    logic       m_en  [NT];
    logic [3:0] m_st  [NT];
    logic [3:0] m_end [NT];
    logic       m_sec [NB];
    logic       m_pr  [NB];
    logic       m_cf  [NB];
    logic [7:0] m_rd  [NB];
    logic [7:0] m_wr  [NB];
    logic [7:0] m_pv  [NB];

    task automatic cfg(input int idx, input logic en, input int s, input int e,
                       input logic sec, input logic pr, input logic cf,
                       input logic [7:0] rd, input logic [7:0] wr, input logic [7:0] pv);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 4'(idx); cfg_en = en;
        cfg_start_pg = 4'(s); cfg_end_pg = 4'(e);
        cfg_sec = sec; cfg_priv = pr; cfg_cid_filt = cf;
        cfg_rd_map = rd; cfg_wr_map = wr; cfg_pv_map = pv;
        m_en[idx] = en; m_st[idx] = 4'(s); m_end[idx] = 4'(e);
        if (idx < NB) begin
            m_sec[idx] = sec; m_pr[idx] = pr; m_cf[idx] = cf;
            m_rd[idx] = rd; m_wr[idx] = wr; m_pv[idx] = pv;
        end
        @(negedge clk);
        cfg_we = 0;
    endtask

    function automatic logic model(input int pg, input int cid, input logic sec,
                                   input logic pr, input logic wr, output string tag);
        if (cid == 7) begin tag = "R10"; return 1'b1; end
        for (int i = 0; i < NB; i++) begin
            if (m_en[i] && pg >= int'(m_st[i]) && pg <= int'(m_end[i])) begin
                if (m_sec[i] && !sec) begin tag = "R4"; return 1'b0; end
                if (m_cf[i]) begin
                    if (wr ? !m_wr[i][cid] : !m_rd[i][cid]) begin tag = "R6"; return 1'b0; end
                    if (m_pv[i][cid] && !pr) begin tag = "R7"; return 1'b0; end
                end else if (m_pr[i] && !pr) begin tag = "R5"; return 1'b0; end
                tag = "R3";
                return 1'b1;
            end
        end
        for (int i = NB; i < NT; i++)
            if (m_en[i] && pg >= int'(m_st[i]) && pg <= int'(m_end[i])) begin
                tag = "R8"; return 1'b1;
            end
        tag = "R9";
        return (cid == 1) && sec && pr;
    endfunction

    task automatic sweep(input string name);
        for (int pg = 0; pg < 16; pg++)
        for (int cid = 0; cid < 8; cid++)
        for (int a = 0; a < 8; a++) begin
            logic sec, pr, wr, ok;
            logic [ADDR_W-1:0] ad;
            logic [DATA_W-1:0] wd;
            logic [66:0] got, exp;
            string tag;
            sec = a[0]; pr = a[1]; wr = a[2];
            ad = {4'(pg), 12'((pg * 37 + cid * 5 + a) & 12'hFFF)};
            wd = {8'(pg), 8'(cid), 8'(a), 8'h5C};
            ok = model(pg, cid, sec, pr, wr, tag);
            @(negedge clk);
            req_valid = 1; req_write = wr; req_addr = ad; req_wdata = wd;
            req_cid = 3'(cid); req_secure = sec; req_priv = pr;
            @(negedge clk);
            req_valid = 0;
            got = {mem_valid, illegal_evt, resp_valid, resp_rdata,
                   (mem_valid ? mem_addr : 16'h0),
                   ((mem_valid && mem_write) ? mem_wdata[15:0] : 16'h0)};
            exp = {ok, !ok, 1'b1,
                   ((ok && !wr) ? {16'hC0DE, ad} : 32'h0),
                   (ok ? ad : 16'h0),
                   ((ok && wr) ? wd[15:0] : 16'h0)};
            checks++;
            if (got !== exp) begin
                fails++;
                $display("FAIL %s/R2/R11 %s pg=%0d cid=%0d sec=%0d priv=%0d wr=%0d actual=%h expected=%h",
                         tag, name, pg, cid, sec, pr, wr, got, exp);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NT; i++) begin m_en[i] = 0; m_st[i] = 0; m_end[i] = 0; end
        for (int i = 0; i < NB; i++) begin
            m_sec[i] = 0; m_pr[i] = 0; m_cf[i] = 0; m_rd[i] = 0; m_wr[i] = 0; m_pv[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        checks++;  // R12 reset state
        if ({mem_valid, resp_valid, illegal_evt} !== 3'b000) begin
            fails++;
            $display("FAIL R12 reset actual=%b expected=000", {mem_valid, resp_valid, illegal_evt});
        end
        // no region enabled: default rule only (R9, R12)
        sweep("reset_layout");

        // overlapping layout: R3 priority, R4-R8 rule paths
        cfg(0,  1, 2, 4,   1, 1, 0, 8'h00, 8'h00, 8'h00);
        cfg(1,  1, 4, 7,   0, 0, 1, 8'h06, 8'h02, 8'h04);
        cfg(2,  1, 9, 9,   0, 0, 0, 8'h00, 8'h00, 8'h00);
        cfg(3,  1, 15, 15, 1, 0, 1, 8'h01, 8'h00, 8'h01);
        cfg(10, 1, 11, 12, 0, 0, 1, 8'hFF, 8'hFF, 8'h00);
        cfg(11, 1, 0, 0,   0, 0, 0, 8'h00, 8'h00, 8'h00);
        cfg(12, 1, 14, 15, 0, 0, 0, 8'h00, 8'h00, 8'h00);
        sweep("overlap_layout");

        // disable region 0 so its pages fall through (R1, R3)
        cfg(0,  0, 2, 4,   1, 1, 0, 8'h00, 8'h00, 8'h00);
        cfg(5,  1, 3, 3,   0, 1, 0, 8'h00, 8'h00, 8'h00);
        sweep("fallthrough_layout");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule